// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Generator

This block maps each of three colour sample streams (red, green, blue) through a programmable transfer curve, one sample per clock in every lane. The curve is made of 16 straight segments of equal width over the 8-bit input range. Seventeen knot levels per channel set the output at each segment boundary, and the output between two knots is interpolated linearly. The same hardware gives gamma correction, contrast stretch, offset and range limiting, depending on the knots loaded.

Knots are loaded through a simple write port that selects a channel, a knot index and a level. The write logic keeps every curve non-decreasing: a level below its lower neighbour is raised to that neighbour, and higher knots that would fall below a new level are raised with it. Since each segment begins at the knot where the previous one ended, the curve is always continuous. Data, valid and the two sync flags pass through a fixed two-clock pipeline.

Top module: `gamma_pwl`

## Requirements
- R1: For an input x, with s = x[7:4] and f = x[3:0], the output is k[s] + floor((k[s+1] - k[s]) * f / 16), where k are the 17 knots of that channel.
- R2: The three channels have separate knot sets; cfg_chan code 0 selects red, 1 green, 2 blue, and a write to one channel leaves the other two curves unchanged.
- R3: A write with cfg_chan = 3 or cfg_idx above 16 changes no knot and leaves all three curves as they were.
- R4: A write to knot j > 0 of a level below knot j-1 stores the level of knot j-1 instead.
- R5: After a write stores level v at knot j, every knot above j that was below v holds v, so each curve stays non-decreasing.
- R6: Both end knots (index 0 and 16) are writable like any other, so input 0 gives knot 0 and input 255 gives k[15] + floor((k[16] - k[15]) * 15 / 16).
- R7: Reset loads knot i with 16*i for i below 16 and knot 16 with 255 in every channel, and drives out_valid, out_hsync, out_vsync and all output samples to 0.
- R8: out_valid, out_hsync, out_vsync and the output samples follow the inputs with a latency of exactly 2 clocks.
- R9: A sample taken on the same clock edge as a knot write uses the curve from before the write; the sample on the next edge uses the new curve.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Knot write strobe |
| cfg_chan | input | 2 | Channel select: 0 red, 1 green, 2 blue |
| cfg_idx | input | 5 | Knot index 0..16 |
| cfg_data | input | 8 | Knot level |
| in_valid | input | 1 | Input sample valid |
| in_hsync | input | 1 | Horizontal sync, delayed with the data |
| in_vsync | input | 1 | Vertical sync, delayed with the data |
| in_r | input | 8 | Red input sample |
| in_g | input | 8 | Green input sample |
| in_b | input | 8 | Blue input sample |
| out_valid | output | 1 | Output sample valid |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_r | output | 8 | Corrected red sample |
| out_g | output | 8 | Corrected green sample |
| out_b | output | 8 | Corrected blue sample |

## Verification
A wrong knot level shows only when a sample falls in one of the two segments that touch that knot, and it then appears at the output two clocks later, so every knot change is followed by a full sweep of input codes on all three lanes. A wrong clamp or push on write stays hidden until a sample reaches the affected segment, which the sweeps after each clamp and push case reach within 256 samples. A slip in the pipeline shows at once as valid or sync flags misaligned with their data, and a write applied one edge early or late shows on the sample next to the write.

// File: rtl/gamma_pwl.sv
module gamma_pwl #(
  parameter int DW       = 8,
  parameter int SEG_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_chan,
  input  logic [SEG_BITS:0]   cfg_idx,
  input  logic [DW-1:0]       cfg_data,
  input  logic                in_valid,
  input  logic                in_hsync,
  input  logic                in_vsync,
  input  logic [DW-1:0]       in_r,
  input  logic [DW-1:0]       in_g,
  input  logic [DW-1:0]       in_b,
  output logic                out_valid,
  output logic                out_hsync,
  output logic                out_vsync,
  output logic [DW-1:0]       out_r,
  output logic [DW-1:0]       out_g,
  output logic [DW-1:0]       out_b
);
  localparam int NSEG  = 1 << SEG_BITS;
  localparam int NKNOT = NSEG + 1;
  localparam int FRAC  = DW - SEG_BITS;
  localparam int PW    = DW + FRAC;
  localparam int STEP  = 1 << FRAC;
  localparam int NCH   = 3;

  logic [NCH-1:0][NKNOT-1:0][DW-1:0] kn;

  logic          wr_ok;
  logic [DW-1:0] floor_v, wr_v;

  assign wr_ok = cfg_we && (cfg_chan != 2'd3) && (cfg_idx <= (SEG_BITS+1)'(NSEG));

  always_comb begin
    floor_v = '0;
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < NSEG; i++)
        if (2'(c) == cfg_chan && (SEG_BITS+1)'(i + 1) == cfg_idx)
          floor_v = kn[c][i];
  end

  assign wr_v = (cfg_data < floor_v) ? floor_v : cfg_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++)
        for (int i = 0; i < NKNOT; i++)
          kn[c][i] <= (i == NKNOT - 1) ? {DW{1'b1}} : DW'(i * STEP);
    end else if (wr_ok) begin
      for (int c = 0; c < NCH; c++)
        if (2'(c) == cfg_chan)
          for (int i = 0; i < NKNOT; i++) begin
            if ((SEG_BITS+1)'(i) == cfg_idx)
              kn[c][i] <= wr_v;
            else if ((SEG_BITS+1)'(i) > cfg_idx && kn[c][i] < wr_v)
              kn[c][i] <= wr_v;
          end
    end
  end

  logic [NCH-1:0][DW-1:0] pix, res;
  assign pix = {in_b, in_g, in_r};

  logic v1, h1, s1, v2, h2, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      {v1, h1, s1, v2, h2, s2} <= '0;
    end else begin
      v1 <= in_valid;
      h1 <= in_hsync;
      s1 <= in_vsync;
      v2 <= v1;
      h2 <= h1;
      s2 <= s1;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    logic [SEG_BITS-1:0] seg;
    logic [SEG_BITS:0]   seg_hi;
    logic [DW-1:0]       lo_k, hi_k;
    logic [DW-1:0]       s1_lo, s1_dif;
    logic [FRAC-1:0]     s1_frac;
    logic [PW-1:0]       prod;
    logic [DW-1:0]       o_q;

    assign seg    = pix[ch][DW-1 -: SEG_BITS];
    assign seg_hi = {1'b0, seg} + 1'b1;
    assign lo_k   = kn[ch][seg];
    assign hi_k   = kn[ch][seg_hi];
    assign prod   = PW'(s1_dif) * PW'(s1_frac);

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_lo   <= '0;
        s1_dif  <= '0;
        s1_frac <= '0;
        o_q     <= '0;
      end else begin
        s1_lo   <= lo_k;
        s1_dif  <= hi_k - lo_k;
        s1_frac <= pix[ch][FRAC-1:0];
        o_q     <= s1_lo + prod[PW-1:FRAC];
      end
    end

    assign res[ch] = o_q;
  end

  assign out_valid = v2;
  assign out_hsync = h2;
  assign out_vsync = s2;
  assign out_r     = res[0];
  assign out_g     = res[1];
  assign out_b     = res[2];
endmodule

// File: rtl/gamma_pwl_chk.sv
module gamma_pwl_chk #(
  parameter int DW       = 8,
  parameter int SEG_BITS = 4
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_hsync,
  input logic in_vsync,
  input logic out_valid,
  input logic out_hsync,
  input logic out_vsync,
  input logic [DW-1:0] out_r,
  input logic [DW-1:0] out_g,
  input logic [DW-1:0] out_b,
  input logic [2:0][(1<<SEG_BITS):0][DW-1:0] knots
);
  localparam int NKNOT = (1 << SEG_BITS) + 1;

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  logic mono;
  always_comb begin
    mono = 1'b1;
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < NKNOT - 1; i++)
        if (knots[c][i] > knots[c][i+1]) mono = 1'b0;
  end

  assert_valid_lat_R8: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_hsync_lat_R8: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_hsync == $past(in_hsync, 2)));

  assert_vsync_lat_R8: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_vsync == $past(in_vsync, 2)));

  assert_monotone_R5: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> mono);

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_hsync && !out_vsync &&
                    out_r == '0 && out_g == '0 && out_b == '0));
endmodule

bind gamma_pwl gamma_pwl_chk #(.DW(DW), .SEG_BITS(SEG_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_hsync  (in_hsync),
  .in_vsync  (in_vsync),
  .out_valid (out_valid),
  .out_hsync (out_hsync),
  .out_vsync (out_vsync),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b),
  .knots     (kn)
);

// File: tb/gamma_pwl_test.sv
`timescale 1ns/1ps
module gamma_pwl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_chan = '0;
  logic [4:0] cfg_idx = '0;
  logic [7:0] cfg_data = '0;
  logic       in_valid = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic       out_valid, out_hsync, out_vsync;
  logic [7:0] out_r, out_g, out_b;

  gamma_pwl uut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_hsync(out_hsync), .out_vsync(out_vsync),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R7";

  int mk [3][17];
  int e1 [6];
  int e2 [6];

  function automatic int eval(int c, int x);
    int s = x / 16;
    int f = x % 16;
    return mk[c][s] + ((mk[c][s+1] - mk[c][s]) * f) / 16;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 17; i++)
        mk[c][i] = (i == 16) ? 255 : 16 * i;
    for (int k = 0; k < 6; k++) begin
      e1[k] = 0;
      e2[k] = 0;
    end
  endtask

  task automatic model_write(int c, int idx, int d);
    int v;
    if (c > 2 || idx > 16) return;
    v = d;
    if (idx > 0 && v < mk[c][idx-1]) v = mk[c][idx-1];
    mk[c][idx] = v;
    for (int j = idx + 1; j < 17; j++)
      if (mk[c][j] < v) mk[c][j] = v;
  endtask

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      for (int k = 0; k < 6; k++) e2[k] = e1[k];
      e1[0] = in_valid;
      e1[1] = in_hsync;
      e1[2] = in_vsync;
      e1[3] = eval(0, in_r);
      e1[4] = eval(1, in_g);
      e1[5] = eval(2, in_b);
      if (cfg_we) model_write(cfg_chan, cfg_idx, cfg_data);
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(out_valid == e2[0], "R8", "out_valid", out_valid, e2[0]);
      chk(out_hsync == e2[1], "R8", "out_hsync", out_hsync, e2[1]);
      chk(out_vsync == e2[2], "R8", "out_vsync", out_vsync, e2[2]);
      chk(out_r == e2[3], cur_req, "out_r", out_r, e2[3]);
      chk(out_g == e2[4], cur_req, "out_g", out_g, e2[4]);
      chk(out_b == e2[5], cur_req, "out_b", out_b, e2[5]);
    end
  end

  task automatic cyc(bit we, int ch, int idx, int d, bit v, bit hs, bit vs, int r, int g, int b);
    @(negedge clk);
    cfg_we   = we;
    cfg_chan = 2'(ch);
    cfg_idx  = 5'(idx);
    cfg_data = 8'(d);
    in_valid = v;
    in_hsync = hs;
    in_vsync = vs;
    in_r = 8'(r);
    in_g = 8'(g);
    in_b = 8'(b);
  endtask

  task automatic wr(int ch, int idx, int d);
    cyc(1'b1, ch, idx, d, 1'b0, 1'b0, 1'b0, 0, 0, 0);
  endtask

  task automatic sweep();
    for (int x = 0; x < 256; x++)
      cyc(1'b0, 0, 0, 0, 1'b1, x == 0, 1'b0, x, 255 - x, x ^ 8'h5A);
    cyc(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, 0);
    cyc(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: outputs cleared while in reset
    chk(out_valid == 1'b0, "R7", "reset out_valid", out_valid, 0);
    chk(out_hsync == 1'b0 && out_vsync == 1'b0, "R7", "reset sync", {out_hsync, out_vsync}, 0);
    chk(out_r == 0 && out_g == 0 && out_b == 0, "R7", "reset data", out_r | out_g | out_b, 0);
    @(negedge clk);
    rst = 1'b0;

    cur_req = "R7";
    sweep();

    cur_req = "R1";
    for (int i = 0; i < 17; i++) wr(0, i, 255 - ((16 - i) * (16 - i) * 255) / 256);
    for (int i = 0; i < 17; i++) wr(1, i, (i * i * 255) / 256);
    for (int i = 0; i < 17; i++) wr(2, i, (i * 8 + 60 > 255) ? 255 : i * 8 + 60);
    sweep();

    cur_req = "R2";
    wr(1, 9, 200);
    sweep();

    cur_req = "R3";
    wr(3, 5, 0);
    wr(0, 20, 0);
    wr(2, 31, 0);
    sweep();

    cur_req = "R4";
    wr(1, 8, 0);
    wr(0, 12, 3);
    sweep();

    cur_req = "R5";
    wr(2, 3, 250);
    wr(1, 1, 180);
    sweep();

    cur_req = "R6";
    for (int i = 0; i < 17; i++) wr(0, i, 40 + 10 * i);
    wr(1, 0, 0);
    for (int i = 1; i < 17; i++) wr(1, i, 16 * i - (i == 16 ? 1 : 0));
    wr(1, 16, 255);
    sweep();

    cur_req = "R9";
    for (int n = 0; n < 64; n++)
      cyc(1'b1, n % 3, n % 17, (n * 37) & 255, 1'b1, 1'b0, n == 0,
          (n * 16 + 7) & 255, (n * 29) & 255, (255 - n * 16) & 255);
    cyc(1'b0, 0, 0, 0, 1'b1, 1'b0, 1'b0, 120, 60, 200);
    cyc(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, 0);
    cyc(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, 0);

    cur_req = "R8";
    for (int n = 0; n < 400; n++) begin
      int rv = int'($urandom);
      cyc(rv[20:18] == 3'd0, (rv >> 4) % 3, (rv >> 8) % 17, (rv >> 12) & 255,
          rv[0], rv[1], rv[2], (rv >> 3) & 255, (rv >> 11) & 255, (rv >> 21) & 255);
    end
    cyc(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, 0);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule